// File: doc/BRIEF.md
# Eight-Channel Endpoint DMA Engine

This block moves 32-bit words between system memory and the data FIFOs of a USB-style endpoint controller. Software programs each of eight channels through a small register window: a start address, a byte count and a control word that binds the channel to one of sixteen endpoints, selects the direction, the operating mode and the memory burst type. The write of the control word with its enable bit set starts the channel; address and count are loaded before it.

An enabled channel waits for its endpoint's data request, then competes for the single memory request port. The lowest-numbered eligible channel wins, and its burst runs to the end before the next arbitration. Every accepted beat advances the channel's live address by four bytes, lowers its count by four and pulses the endpoint's acknowledge line, so software learns the bytes moved by subtracting the start address from the current address. In single-packet mode a channel stops after one packet of `PKT_WORDS` words; in buffer mode it keeps serving endpoint requests until the count is used up. A memory error freezes the channel with a sticky flag. Finished or failed channels set a bit in a shared status byte that clears when read, and the interrupt output is the OR of those bits.

Top module: `ep_dma_engine`

## Requirements
- R1: After reset every channel register reads zero, the status byte reads zero, `irq` is low and `mem_req` is low.
- R2: The status byte sits at window offset 0x200 (bit n = channel n); channel n owns a 16-byte slot at 0x200 + 16n holding control at +0x4 (11 bits, upper bits read 0), address at +0x8 and count at +0xC, each readable back after a write and independent of the other channels.
- R3: A channel makes no memory request while its control enable bit (bit 0) is 0 or while the data request of the endpoint named in control bits 7:4 is low.
- R4: Each accepted beat advances the channel's address register by 4 and lowers its count by 4; the count is taken as a number of words (count >> 2), and the address stays stable while a beat is stalled.
- R5: With control bit 2 set (buffer mode) a channel keeps moving words until its word count reaches zero.
- R6: With control bit 2 clear (single-packet mode) a channel moves at most `PKT_WORDS` (16) words per start and then completes; a new control write starts the next packet from the current address and count.
- R7: On completion the enable bit clears; the channel's status bit is set only if control bit 3 is 1; a channel started with a zero word count completes at once.
- R8: Control bits 10:9 select the burst (0 single, 1 four beats, 2 eight, 3 sixteen) and appear on `mem_burst`; a burst never exceeds that length, the remaining words or the remaining packet room.
- R9: Control bit 1 = 1 (transmit) reads memory (`mem_write` low); bit 1 = 0 (receive) writes memory (`mem_write` high).
- R10: A beat answered with `mem_err` is not counted, ends the burst, sets control bit 8, clears the enable bit and sets the status bit regardless of bit 3; the next control write clears bit 8.
- R11: Writing zero to an active channel's control word ends its burst on the next cycle and raises no status bit; address and count can then be written to zero.
- R12: Reading the status byte returns the pending bits and clears them; `irq` is high exactly while any bit is pending.
- R13: With several channels eligible the lowest channel number is served first, and a granted burst runs to its end before re-arbitration.
- R14: Each accepted beat pulses exactly one bit of `ep_ack`, the endpoint bound to the active channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status on its address) |
| reg_addr | input | 10 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ep_req | input | 16 | Per-endpoint data request |
| ep_ack | output | 16 | Per-endpoint beat acknowledge |
| ep_rx_data | input | 32 | Word from endpoint FIFO (receive) |
| ep_tx_data | output | 32 | Word to endpoint FIFO (transmit) |
| mem_req | output | 1 | Memory request, held for the whole burst |
| mem_write | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Byte address of current beat |
| mem_burst | output | 2 | Burst type of the active channel |
| mem_wdata | output | 32 | Write data to memory |
| mem_rdata | input | 32 | Read data from memory |
| mem_ready | input | 1 | Beat accepted this cycle |
| mem_err | input | 1 | Bus error on this beat |
| irq | output | 1 | OR of pending status bits |

## Verification
Every cycle the assertions check the memory port discipline: a stalled beat keeps its address and burst type, consecutive beats step by four bytes, a burst drops its request after its last beat or an error, the remaining length never exceeds the burst type, and endpoint acknowledges are one-hot and coincide with accepted beats. Values that only show up after a whole transfer need the bench scenarios: final address and count per mode, packet truncation, status setting with and without interrupt enable, clear-on-read, abort, the error flag, and the order in which competing channels are served.

// File: rtl/ep_dma_pkg.sv
package ep_dma_pkg;

  // Control word field positions (software-visible layout)
  localparam int CTL_EN    = 0;
  localparam int CTL_DIR   = 1;
  localparam int CTL_MODE  = 2;
  localparam int CTL_IE    = 3;
  localparam int CTL_EP_LO = 4;
  localparam int CTL_BERR  = 8;
  localparam int CTL_BT_LO = 9;

  localparam logic [3:0] OFS_STAT = 4'h0;
  localparam logic [3:0] OFS_CTL  = 4'h4;
  localparam logic [3:0] OFS_ADR  = 4'h8;
  localparam logic [3:0] OFS_CNT  = 4'hC;

  typedef enum logic [1:0] {
    BT_SINGLE = 2'd0,
    BT_X4     = 2'd1,
    BT_X8     = 2'd2,
    BT_X16    = 2'd3
  } burst_e;

  function automatic logic [4:0] burst_beats(input logic [1:0] bt);
    case (burst_e'(bt))
      BT_X4:   burst_beats = 5'd4;
      BT_X8:   burst_beats = 5'd8;
      BT_X16:  burst_beats = 5'd16;
      default: burst_beats = 5'd1;
    endcase
  endfunction

endpackage

// File: rtl/ep_dma_arb.sv
module ep_dma_arb #(
  parameter int N  = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  output logic [W-1:0] idx,
  output logic         any
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = i[W-1:0];
    end
  end
endmodule

// File: rtl/ep_dma_chan.sv
module ep_dma_chan
  import ep_dma_pkg::*;
#(
  parameter int PKT_WORDS = 16,
  localparam int PW = $clog2(PKT_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctl,
  input  logic          wr_adr,
  input  logic          wr_cnt,
  input  logic [31:0]   wdata,
  input  logic          beat,
  input  logic          err,
  input  logic          self_busy,
  output logic [15:0]   ctl,
  output logic [31:0]   adr,
  output logic [31:0]   cnt,
  output logic [PW-1:0] pkt,
  output logic          evt
);
  logic [10:0]   ctl_q, ctl_d;
  logic [31:0]   adr_d, cnt_d;
  logic [PW-1:0] pkt_d;
  logic          done_c;

  assign done_c = ctl_q[CTL_EN] && !self_busy &&
                  ((cnt[31:2] == '0) ||
                   (!ctl_q[CTL_MODE] && pkt == PW'(PKT_WORDS)));
  assign evt = !wr_ctl && (err || (done_c && ctl_q[CTL_IE]));
  assign ctl = {5'b0, ctl_q};

  always_comb begin
    ctl_d = ctl_q;
    adr_d = adr;
    cnt_d = cnt;
    pkt_d = pkt;
    if (wr_ctl) begin
      ctl_d           = wdata[10:0];
      ctl_d[CTL_BERR] = 1'b0;
      pkt_d           = '0;
    end else begin
      if (err) begin
        ctl_d[CTL_BERR] = 1'b1;
        ctl_d[CTL_EN]   = 1'b0;
      end else if (beat) begin
        adr_d = adr + 32'd4;
        cnt_d = cnt - 32'd4;
        pkt_d = pkt + 1'b1;
      end
      if (done_c) ctl_d[CTL_EN] = 1'b0;
    end
    if (wr_adr) adr_d = wdata;
    if (wr_cnt) cnt_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      adr   <= '0;
      cnt   <= '0;
      pkt   <= '0;
    end else begin
      ctl_q <= ctl_d;
      adr   <= adr_d;
      cnt   <= cnt_d;
      pkt   <= pkt_d;
    end
  end
endmodule

// File: rtl/ep_dma_engine.sv
module ep_dma_engine
  import ep_dma_pkg::*;
#(
  parameter int          NCH       = 8,
  parameter int          AW        = 10,
  parameter logic [9:0]  BASE      = 10'h200,
  parameter int          PKT_WORDS = 16,
  localparam int         CHW       = $clog2(NCH),
  localparam int         SLOT_SH   = 4,
  localparam int         HI        = SLOT_SH + CHW,
  localparam int         PW        = $clog2(PKT_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [15:0]   ep_req,
  output logic [15:0]   ep_ack,
  input  logic [31:0]   ep_rx_data,
  output logic [31:0]   ep_tx_data,
  output logic          mem_req,
  output logic          mem_write,
  output logic [31:0]   mem_addr,
  output logic [1:0]    mem_burst,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ready,
  input  logic          mem_err,
  output logic          irq
);
  logic [15:0]    ctl_a [NCH];
  logic [31:0]    adr_a [NCH];
  logic [31:0]    cnt_a [NCH];
  logic [PW-1:0]  pkt_a [NCH];
  logic [NCH-1:0] evt, elig;
  logic [NCH-1:0] pend, pend_d;
  logic           busy, busy_d;
  logic [CHW-1:0] act, act_d, gnt;
  logic [4:0]     beats_left, beats_d, len_c;
  logic           any_elig, win, rd_clr, abort_act, beat_ok, err_hit;
  logic [CHW-1:0] slot;
  logic [3:0]     ofs;

  // Register window decode
  assign win  = reg_addr[AW-1:HI] == BASE[AW-1:HI];
  assign slot = reg_addr[HI-1:SLOT_SH];
  assign ofs  = reg_addr[SLOT_SH-1:0];
  assign rd_clr = reg_rd && win && slot == '0 && ofs == OFS_STAT;

  always_comb begin
    reg_rdata = '0;
    if (win) begin
      case (ofs)
        OFS_STAT: if (slot == '0) reg_rdata = 32'(pend);
        OFS_CTL:  reg_rdata = {16'b0, ctl_a[slot]};
        OFS_ADR:  reg_rdata = adr_a[slot];
        OFS_CNT:  reg_rdata = cnt_a[slot];
        default:  reg_rdata = '0;
      endcase
    end
  end

  // Burst engine strobes
  assign abort_act = busy && reg_wr && win && slot == act && ofs == OFS_CTL;
  assign beat_ok   = busy && mem_ready && !mem_err && !abort_act;
  assign err_hit   = busy && mem_err && !abort_act;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sel;
    assign sel = reg_wr && win && slot == CHW'(g);
    assign elig[g] = ctl_a[g][CTL_EN] && !ctl_a[g][CTL_BERR] &&
                     (cnt_a[g][31:2] != '0) &&
                     (ctl_a[g][CTL_MODE] || pkt_a[g] < PW'(PKT_WORDS)) &&
                     ep_req[ctl_a[g][CTL_EP_LO+:4]];
    ep_dma_chan #(.PKT_WORDS(PKT_WORDS)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctl    (sel && ofs == OFS_CTL),
      .wr_adr    (sel && ofs == OFS_ADR),
      .wr_cnt    (sel && ofs == OFS_CNT),
      .wdata     (reg_wdata),
      .beat      (beat_ok && act == CHW'(g)),
      .err       (err_hit && act == CHW'(g)),
      .self_busy (busy && act == CHW'(g)),
      .ctl       (ctl_a[g]),
      .adr       (adr_a[g]),
      .cnt       (cnt_a[g]),
      .pkt       (pkt_a[g]),
      .evt       (evt[g])
    );
  end

  ep_dma_arb #(.N(NCH)) u_arb (
    .req (elig),
    .idx (gnt),
    .any (any_elig)
  );

  // Length of the burst about to be granted
  always_comb begin
    logic [31:0] words;
    logic [PW:0] room;
    words = {2'b0, cnt_a[gnt][31:2]};
    room  = (PW+1)'(PKT_WORDS) - {1'b0, pkt_a[gnt]};
    len_c = burst_beats(ctl_a[gnt][CTL_BT_LO+:2]);
    if (words < 32'(len_c)) len_c = words[4:0];
    if (!ctl_a[gnt][CTL_MODE] && 32'(room) < 32'(len_c)) len_c = 5'(room);
  end

  always_comb begin
    busy_d  = busy;
    act_d   = act;
    beats_d = beats_left;
    if (busy) begin
      if (beat_ok) beats_d = beats_left - 5'd1;
      if (abort_act || err_hit || (beat_ok && beats_left == 5'd1)) busy_d = 1'b0;
    end else if (any_elig && !(reg_wr && win)) begin
      busy_d  = 1'b1;
      act_d   = gnt;
      beats_d = len_c;
    end
    pend_d = (rd_clr ? '0 : pend) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      act        <= '0;
      beats_left <= '0;
      pend       <= '0;
    end else begin
      busy       <= busy_d;
      act        <= act_d;
      beats_left <= beats_d;
      pend       <= pend_d;
    end
  end

  // Port side
  always_comb begin
    ep_ack = '0;
    if (beat_ok) ep_ack[ctl_a[act][CTL_EP_LO+:4]] = 1'b1;
  end

  assign mem_req    = busy;
  assign mem_addr   = adr_a[act];
  assign mem_write  = !ctl_a[act][CTL_DIR];
  assign mem_burst  = ctl_a[act][CTL_BT_LO+:2];
  assign mem_wdata  = ep_rx_data;
  assign ep_tx_data = mem_rdata;
  assign irq        = |pend;

endmodule

// File: rtl/ep_dma_sva.sv
module ep_dma_sva
  import ep_dma_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        mem_req,
  input logic        mem_ready,
  input logic        mem_err,
  input logic [31:0] mem_addr,
  input logic [1:0]  mem_burst,
  input logic [15:0] ep_ack,
  input logic [4:0]  beats_left
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready && !mem_err && !reg_wr |=> mem_req && $stable(mem_addr) && $stable(mem_burst)); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ready && !mem_err && !reg_wr && beats_left > 5'd1 |=> mem_req && mem_addr == $past(mem_addr) + 32'd4); // R4

  AST_BURST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> beats_left != 5'd0 && beats_left <= burst_beats(mem_burst)); // R8

  AST_BURST_END: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ready && !mem_err && beats_left == 5'd1 |=> !mem_req); // R13

  AST_ERR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_err |=> !mem_req); // R10

  AST_ACK_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_ack != 16'd0) |-> mem_req && mem_ready && !mem_err); // R14

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ep_ack)); // R14
endmodule

bind ep_dma_engine ep_dma_sva u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .mem_req    (mem_req),
  .mem_ready  (mem_ready),
  .mem_err    (mem_err),
  .mem_addr   (mem_addr),
  .mem_burst  (mem_burst),
  .ep_ack     (ep_ack),
  .beats_left (beats_left)
);

// File: tb/ep_dma_engine_tb.sv
`timescale 1ns/1ps
module ep_dma_engine_tb;
  logic        clk, rst_n;
  logic        reg_wr, reg_rd;
  logic [9:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [15:0] ep_req, ep_ack;
  logic [31:0] ep_rx_data, ep_tx_data;
  logic        mem_req, mem_write, mem_ready, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_burst;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  int stall_mode = 0, err_at = 0, cur_ep = -1;
  int nbeats = 0, run = 0, nruns = 0, ack_bad = 0;
  logic        last_write;
  logic [31:0] beat_addr [0:255];
  int          runs [0:63];

  ep_dma_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ep_req(ep_req), .ep_ack(ep_ack), .ep_rx_data(ep_rx_data),
    .ep_tx_data(ep_tx_data), .mem_req(mem_req), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_burst(mem_burst), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .mem_err(mem_err),
    .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int bb(input int b);
    case (b) 1: bb = 4; 2: bb = 8; 3: bb = 16; default: bb = 1; endcase
  endfunction
  function automatic int moved(input int mode, input int cnt);
    if (mode != 0 || cnt < 64) moved = cnt; else moved = 64;
  endfunction
  function automatic logic [9:0] ra(input int ch, input int ofs);
    ra = 10'(32'h200 + ch * 16 + ofs);
  endfunction
  function automatic logic [31:0] cw(input int en, input int dir, input int mode,
                                     input int ie, input int ep, input int bt);
    cw = 32'(en | (dir << 1) | (mode << 2) | (ie << 3) | (ep << 4) | (bt << 9));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_done(input int ch);
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      rd(ra(ch, 4), v);
      if (!v[0]) break;
    end
  endtask

  task automatic clr_trace();
    nbeats = 0; run = 0; nruns = 0; ack_bad = 0;
  endtask

  // Memory responder and beat monitor
  initial begin
    mem_ready = 1'b0; mem_err = 1'b0; mem_rdata = 32'h0;
    forever begin
      @(negedge clk);
      case (stall_mode)
        1: mem_ready = ($urandom % 4) != 0;
        2: mem_ready = 1'b0;
        default: mem_ready = 1'b1;
      endcase
      mem_err = (err_at != 0) && mem_req && (nbeats == err_at - 1);
      mem_rdata = mem_addr ^ 32'hA5A5_0000;
      #1;
      if (mem_req && mem_ready && !mem_err) begin
        if (nbeats < 256) beat_addr[nbeats] = mem_addr;
        last_write = mem_write;
        if (cur_ep >= 0 && ep_ack !== (16'h1 << cur_ep)) ack_bad++;
        nbeats++; run++;
      end else if (!mem_req && run > 0) begin
        if (nruns < 64) runs[nruns] = run;
        nruns++; run = 0;
      end
    end
  end

  task automatic run_tests();
    logic [31:0] v;
    // ---- R1 reset state
    chk(irq == 1'b0, "R1 irq after reset", 32'(irq), 0);
    chk(mem_req == 1'b0, "R1 mem_req after reset", 32'(mem_req), 0);
    rd(ra(0, 4), v); chk(v == 0, "R1 ctl ch0", v, 0);
    rd(ra(7, 8), v); chk(v == 0, "R1 adr ch7", v, 0);
    rd(ra(0, 0), v); chk(v == 0, "R1 status", v, 0);

    // ---- R2 register map
    wr(ra(5, 8), 32'hABCD_0000);
    rd(ra(5, 8), v); chk(v == 32'hABCD_0000, "R2 adr readback", v, 32'hABCD_0000);
    rd(ra(4, 8), v); chk(v == 0, "R2 neighbour adr", v, 0);
    wr(ra(5, 4), 32'h0000_F654);
    rd(ra(5, 4), v); chk(v == 32'h0654, "R2 ctl width", v, 32'h0654);
    wr(ra(5, 4), 0); wr(ra(5, 8), 0);

    // ---- R3 disabled channel / missing endpoint request
    clr_trace();
    ep_req = 16'h0001;
    wr(ra(0, 8), 32'h100); wr(ra(0, 12), 32'd64);
    wr(ra(0, 4), cw(0, 0, 1, 1, 0, 1));
    repeat (30) @(negedge clk);
    chk(nbeats == 0, "R3 enable clear", nbeats, 0);
    ep_req = 16'h0;
    wr(ra(0, 4), cw(1, 0, 1, 1, 0, 1));
    repeat (30) @(negedge clk);
    chk(nbeats == 0, "R3 no ep request", nbeats, 0);
    rd(ra(0, 12), v); chk(v == 64, "R3 count untouched", v, 64);
    wr(ra(0, 4), 0);

    // ---- R4 R5 R8 R9 R14 buffer mode receive, four-beat bursts
    clr_trace(); cur_ep = 3;
    wr(ra(0, 8), 32'h1000); wr(ra(0, 12), 32'd40);
    wr(ra(0, 4), cw(1, 0, 1, 1, 3, 1));
    ep_req = 16'h0008;
    wait_done(0);
    rd(ra(0, 8), v);  chk(v == 32'h1028, "R4 final address", v, 32'h1028);
    rd(ra(0, 12), v); chk(v == 0, "R5 count drained", v, 0);
    chk(nbeats == 10, "R5 beat total", nbeats, 10);
    chk(nruns == 3 && runs[0] == 4 && runs[1] == 4 && runs[2] == 2,
        "R8 burst split 4/4/2", 32'(nruns), 3);
    chk(beat_addr[9] == 32'h1024, "R4 last beat address", beat_addr[9], 32'h1024);
    chk(last_write == 1'b1, "R9 receive writes memory", 32'(last_write), 1);
    chk(ack_bad == 0, "R14 endpoint acknowledge", ack_bad, 0);
    chk(irq == 1'b1, "R12 irq raised", 32'(irq), 1);
    rd(ra(0, 0), v); chk(v == 32'h01, "R12 status read", v, 1);
    rd(ra(0, 0), v); chk(v == 0, "R12 status cleared", v, 0);
    chk(irq == 1'b0, "R12 irq cleared", 32'(irq), 0);
    ep_req = 0;

    // ---- R6 R9 single-packet transmit, sixteen-beat bursts
    clr_trace(); cur_ep = 5;
    wr(ra(1, 8), 32'h2000); wr(ra(1, 12), 32'd200);
    wr(ra(1, 4), cw(1, 1, 0, 1, 5, 3));
    ep_req = 16'h0020;
    wait_done(1);
    rd(ra(1, 8), v);  chk(v == 32'h2040, "R6 one packet address", v, 32'h2040);
    rd(ra(1, 12), v); chk(v == 136, "R6 one packet count", v, 136);
    chk(nruns == 1 && runs[0] == 16, "R8 sixteen-beat burst", 32'(runs[0]), 16);
    chk(last_write == 1'b0, "R9 transmit reads memory", 32'(last_write), 0);
    rd(ra(0, 0), v); chk(v == 32'h02, "R7 status ch1", v, 2);
    wr(ra(1, 4), cw(1, 1, 0, 1, 5, 3));
    wait_done(1);
    rd(ra(1, 8), v);  chk(v == 32'h2080, "R6 second packet address", v, 32'h2080);
    rd(ra(1, 12), v); chk(v == 72, "R6 second packet count", v, 72);
    rd(ra(0, 0), v);
    ep_req = 0;

    // ---- R13 priority and burst atomicity
    clr_trace(); cur_ep = -1;
    wr(ra(5, 8), 32'h5000); wr(ra(5, 12), 32'd32);
    wr(ra(5, 4), cw(1, 0, 1, 1, 6, 1));
    wr(ra(2, 8), 32'h3000); wr(ra(2, 12), 32'd32);
    wr(ra(2, 4), cw(1, 0, 1, 1, 2, 1));
    @(negedge clk); ep_req = 16'h0044;
    wait_done(5);
    chk(nbeats == 16, "R13 beat total", nbeats, 16);
    chk(beat_addr[0] == 32'h3000, "R13 lowest channel first", beat_addr[0], 32'h3000);
    chk(beat_addr[7] == 32'h301C, "R13 ch2 served fully", beat_addr[7], 32'h301C);
    chk(beat_addr[8] == 32'h5000, "R13 ch5 after ch2", beat_addr[8], 32'h5000);
    rd(ra(0, 0), v); chk(v == 32'h24, "R12 two pending bits", v, 32'h24);
    ep_req = 0;

    // ---- R10 bus error
    clr_trace(); cur_ep = 1; err_at = 2;
    wr(ra(3, 8), 32'h4000); wr(ra(3, 12), 32'd64);
    wr(ra(3, 4), cw(1, 0, 1, 0, 1, 2));
    ep_req = 16'h0002;
    wait_done(3);
    err_at = 0;
    rd(ra(3, 4), v);  chk(v == (cw(0, 0, 1, 0, 1, 2) | 32'h100), "R10 error flag set", v, cw(0, 0, 1, 0, 1, 2) | 32'h100);
    rd(ra(3, 8), v);  chk(v == 32'h4004, "R10 failed beat not counted", v, 32'h4004);
    rd(ra(3, 12), v); chk(v == 60, "R10 count after error", v, 60);
    rd(ra(0, 0), v);  chk(v == 32'h08, "R10 status without ie", v, 8);
    ep_req = 0;
    wr(ra(3, 4), cw(0, 0, 1, 0, 1, 2));
    rd(ra(3, 4), v);  chk(v == cw(0, 0, 1, 0, 1, 2), "R10 flag cleared by write", v, cw(0, 0, 1, 0, 1, 2));

    // ---- R11 abort of a stalled burst
    clr_trace(); cur_ep = 7; stall_mode = 2;
    wr(ra(4, 8), 32'h6000); wr(ra(4, 12), 32'd64);
    wr(ra(4, 4), cw(1, 0, 1, 1, 7, 1));
    ep_req = 16'h0080;
    for (int i = 0; i < 50 && !mem_req; i++) @(negedge clk);
    chk(mem_req == 1'b1, "R11 burst pending", 32'(mem_req), 1);
    wr(ra(4, 4), 0);
    chk(mem_req == 1'b0, "R11 request dropped", 32'(mem_req), 0);
    wr(ra(4, 8), 0); wr(ra(4, 12), 0);
    stall_mode = 0; ep_req = 0;
    repeat (5) @(negedge clk);
    rd(ra(4, 8), v); chk(v == 0, "R11 address zeroed", v, 0);
    rd(ra(0, 0), v); chk(v == 0, "R11 no status", v, 0);
    chk(nbeats == 0, "R11 no beats", nbeats, 0);

    // ---- R7 ie clear, and zero count
    clr_trace(); cur_ep = 9;
    wr(ra(6, 8), 32'h7000); wr(ra(6, 12), 32'd8);
    wr(ra(6, 4), cw(1, 0, 1, 0, 9, 0));
    ep_req = 16'h0200;
    wait_done(6);
    rd(ra(6, 12), v); chk(v == 0, "R7 ie=0 transfer done", v, 0);
    chk(irq == 1'b0, "R7 no irq without ie", 32'(irq), 0);
    ep_req = 0;
    wr(ra(7, 12), 0);
    wr(ra(7, 4), cw(1, 0, 1, 1, 0, 0));
    repeat (3) @(negedge clk);
    rd(ra(7, 4), v); chk(v[0] == 1'b0, "R7 zero count completes", v, 0);
    rd(ra(0, 0), v); chk(v == 32'h80, "R7 zero count status", v, 32'h80);

    // ---- Random transfers
    stall_mode = 1;
    for (int t = 0; t < 8; t++) begin
      int ch, mode, bt, cnt, ep, mx;
      logic [31:0] base;
      ch = $urandom % 8; mode = $urandom % 2; bt = $urandom % 4;
      cnt = 4 * (1 + $urandom % 40); ep = $urandom % 16;
      base = 32'h8000 + 32'(ch) * 32'h1000;
      clr_trace(); cur_ep = ep;
      wr(ra(ch, 8), base); wr(ra(ch, 12), 32'(cnt));
      wr(ra(ch, 4), cw(1, $urandom % 2, mode, 1, ep, bt));
      ep_req = 16'h1 << ep;
      wait_done(ch);
      ep_req = 0;
      rd(ra(ch, 8), v);
      chk(v == base + 32'(moved(mode, cnt)), mode ? "R5 random address" : "R6 random address", v, base + 32'(moved(mode, cnt)));
      rd(ra(ch, 12), v);
      chk(v == 32'(cnt - moved(mode, cnt)), "R4 random count", v, 32'(cnt - moved(mode, cnt)));
      mx = 0;
      for (int k = 0; k < nruns && k < 64; k++) if (runs[k] > mx) mx = runs[k];
      chk(mx <= bb(bt), "R8 random burst cap", mx, bb(bt));
      chk(ack_bad == 0, "R14 random acknowledge", ack_bad, 0);
      rd(ra(0, 0), v);
      chk(v == (32'h1 << ch), "R12 random status", v, 32'h1 << ch);
    end
    stall_mode = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    ep_req = '0; ep_rx_data = 32'h1234_5678; last_write = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule